// File: doc/BRIEF.md
# Converter Sample Output Formatter

This block sits between a 12-bit converter core and the output pins. Each sample clock, the core may hand over one raw sample in offset-binary form, together with a flag that marks an over-range input. The block decides what goes out. It sends either the real sample or one of several fixed or user-defined test patterns. It then codes the chosen word as offset binary, two's complement or Gray code. The result is registered, and the over-range flag is carried through the same register so that it stays with its own sample.

The test-pattern choice, the output coding and the two user test words all come from static register inputs. The block keeps a single alternation phase. This phase flips once for every accepted sample. The checkerboard pattern and the alternating user-word pattern both read this phase, so a test setup can predict exactly which word appears next.

Top module: `adc_data_formatter`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid`, `out_data` and `out_ovr` are all zero.
- R2: `out_valid` equals `in_valid` delayed by exactly one clock. `out_data` and `out_ovr` are loaded only on a cycle in which `in_valid` is high, and they keep their values on every other cycle.
- R3: `out_ovr` is `in_ovr` from the same accepted sample. This holds in every test mode.
- R4: With test mode 0 and coding 0, `out_data` equals `in_sample`.
- R5: Before coding, test mode 1 gives 0x800, test mode 2 gives 0xFFF and test mode 3 gives 0x000, whatever `in_sample` holds.
- R6: Test mode 4 gives 0xAAA when the alternation phase is 0 and 0x555 when it is 1. Both values are before coding.
- R7: Test mode 7 gives user word 1 when the phase is 0 and user word 2 when it is 1. Each user word is built as {hi[3:0], lo[7:0]}, and bits 7:4 of the high byte are ignored.
- R8: Test modes 5, 6 and 8 to 15 behave exactly like mode 0.
- R9: Coding 1 (two's complement) inverts bit 11 of the selected word and leaves the other bits unchanged.
- R10: Coding 2 (Gray) sets bit 11 to bit 11 of the word, and sets each lower bit k to the XOR of bits k and k+1.
- R11: Coding 3 behaves like coding 0 (offset binary, unchanged).
- R12: The phase is 0 after reset. It flips on every cycle with `in_valid` high, in any test mode, and holds on cycles with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is offered this cycle |
| in_sample | input | 12 | Raw offset-binary sample |
| in_ovr | input | 1 | Over-range flag of the offered sample |
| cfg_test_mode | input | 4 | Pattern selection (0 real data, 1 mid, 2 +full, 3 -full, 4 checker, 7 user pair) |
| cfg_coding | input | 2 | Output coding (0 offset, 1 two's complement, 2 Gray, 3 offset) |
| cfg_user1_lo | input | 8 | User word 1, bits 7:0 |
| cfg_user1_hi | input | 8 | User word 1, bits 11:8 in [3:0] |
| cfg_user2_lo | input | 8 | User word 2, bits 7:0 |
| cfg_user2_hi | input | 8 | User word 2, bits 11:8 in [3:0] |
| out_valid | output | 1 | Registered output word is new |
| out_data | output | 12 | Registered coded output word |
| out_ovr | output | 1 | Registered over-range flag aligned with `out_data` |

## Verification
Pattern selection and output coding act on the same word in the same cycle. The bench therefore sweeps every test mode against every coding, so that each fixed pattern, each checkerboard phase and each user word also passes through the two's-complement and Gray steps. In addition, all 4096 sample values pass through the real-data path with the coding rotating on each sample. The over-range flag toggles throughout, including while a test pattern is selected. Idle gaps are placed between samples to show that the phase and the outputs hold. Every expected word is computed in the bench from a modelled phase and from arithmetic on the selected value.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
    localparam int DATA_W = 12;
    localparam int BYTE_W = 8;
    localparam int HI_W   = DATA_W - BYTE_W;

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [3:0] {
        TM_OFF     = 4'd0,
        TM_MID     = 4'd1,
        TM_POS_FS  = 4'd2,
        TM_NEG_FS  = 4'd3,
        TM_CHECKER = 4'd4,
        TM_USER    = 4'd7
    } test_mode_e;

    typedef enum logic [1:0] {
        CODE_OFFSET = 2'd0,
        CODE_TWOS   = 2'd1,
        CODE_GRAY   = 2'd2,
        CODE_RSVD   = 2'd3
    } coding_e;

    localparam word_t MID_WORD   = word_t'(1) << (DATA_W - 1);
    localparam word_t POS_WORD   = '1;
    localparam word_t NEG_WORD   = '0;

    function automatic word_t checker_word(input logic odd);
        word_t w;
        for (int k = 0; k < DATA_W; k++) w[k] = (k % 2 == 1) ^ odd;
        return w;
    endfunction

    typedef struct packed {
        word_t data;
        logic  ovr;
    } sample_t;

    function automatic word_t user_word(input logic [BYTE_W-1:0] hi,
                                        input logic [BYTE_W-1:0] lo);
        return {hi[HI_W-1:0], lo};
    endfunction
endpackage

// File: rtl/fmt_pattern_sel.sv
module fmt_pattern_sel
    import fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  sample_t           raw,
    input  logic [3:0]        test_mode,
    input  logic [BYTE_W-1:0] user1_lo,
    input  logic [BYTE_W-1:0] user1_hi,
    input  logic [BYTE_W-1:0] user2_lo,
    input  logic [BYTE_W-1:0] user2_hi,
    output sample_t           picked
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst)           phase_q <= 1'b0;
        else if (in_valid) phase_q <= ~phase_q;
    end

    always_comb begin
        picked.ovr = raw.ovr;
        unique case (test_mode)
            TM_MID:     picked.data = MID_WORD;
            TM_POS_FS:  picked.data = POS_WORD;
            TM_NEG_FS:  picked.data = NEG_WORD;
            TM_CHECKER: picked.data = checker_word(phase_q);
            TM_USER:    picked.data = phase_q ? user_word(user2_hi, user2_lo)
                                              : user_word(user1_hi, user1_lo);
            default:    picked.data = raw.data;
        endcase
    end

    // R12: phase holds across idle cycles
    p_phase_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(phase_q));
endmodule

// File: rtl/fmt_coder.sv
module fmt_coder
    import fmt_pkg::*;
(
    input  sample_t    din,
    input  logic [1:0] coding,
    output sample_t    dout
);
    word_t gray_w;

    generate
        for (genvar k = 0; k < DATA_W - 1; k++) begin : g_gray
            assign gray_w[k] = din.data[k] ^ din.data[k+1];
        end
    endgenerate
    assign gray_w[DATA_W-1] = din.data[DATA_W-1];

    always_comb begin
        dout.ovr = din.ovr;
        unique case (coding)
            CODE_TWOS: dout.data = {~din.data[DATA_W-1], din.data[DATA_W-2:0]};
            CODE_GRAY: dout.data = gray_w;
            default:   dout.data = din.data;
        endcase
    end

    // R9: only the top bit can differ in two's complement coding
    always_comb begin
        if (coding == CODE_TWOS)
            a_twos_one_bit_r9: assert ($countones(dout.data ^ din.data) == 1);
    end
endmodule

// File: rtl/fmt_out_reg.sv
module fmt_out_reg
    import fmt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  sample_t din,
    output logic    out_valid,
    output sample_t dout
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            dout      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) dout <= din;
        end
    end
endmodule

// File: rtl/adc_data_formatter.sv
module adc_data_formatter
    import fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_sample,
    input  logic              in_ovr,
    input  logic [3:0]        cfg_test_mode,
    input  logic [1:0]        cfg_coding,
    input  logic [BYTE_W-1:0] cfg_user1_lo,
    input  logic [BYTE_W-1:0] cfg_user1_hi,
    input  logic [BYTE_W-1:0] cfg_user2_lo,
    input  logic [BYTE_W-1:0] cfg_user2_hi,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_ovr
);
    sample_t raw_s, picked_s, coded_s, reg_s;

    assign raw_s.data = in_sample;
    assign raw_s.ovr  = in_ovr;

    fmt_pattern_sel u_sel (
        .clk(clk), .rst(rst), .in_valid(in_valid), .raw(raw_s),
        .test_mode(cfg_test_mode),
        .user1_lo(cfg_user1_lo), .user1_hi(cfg_user1_hi),
        .user2_lo(cfg_user2_lo), .user2_hi(cfg_user2_hi),
        .picked(picked_s)
    );

    fmt_coder u_coder (.din(picked_s), .coding(cfg_coding), .dout(coded_s));

    fmt_out_reg u_oreg (
        .clk(clk), .rst(rst), .in_valid(in_valid), .din(coded_s),
        .out_valid(out_valid), .dout(reg_s)
    );

    assign out_data = reg_s.data;
    assign out_ovr  = reg_s.ovr;

    p_valid_latency_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> out_valid == $past(in_valid));
    p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data) && $stable(out_ovr));
    p_ovr_align_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_ovr == $past(in_ovr));
    p_posfs_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid && cfg_test_mode == 4'd2 && cfg_coding == 2'd0 |=> out_data == 12'hFFF);
    p_mid_twos_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid && cfg_test_mode == 4'd1 && cfg_coding == 2'd1 |=> out_data == 12'h000);
    p_mid_gray_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid && cfg_test_mode == 4'd1 && cfg_coding == 2'd2 |=> out_data == 12'hC00);
endmodule

// File: tb/adc_data_formatter_tb.sv
module adc_data_formatter_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] in_sample = '0;
    logic        in_ovr = 1'b0;
    logic [3:0]  cfg_test_mode = '0;
    logic [1:0]  cfg_coding = '0;
    logic [7:0]  u1lo = 8'h3C, u1hi = 8'hF9, u2lo = 8'hA5, u2hi = 8'h62;
    logic        out_valid, out_ovr;
    logic [11:0] out_data;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;
    bit phase = 0;

    always #10 clk = ~clk;

    adc_data_formatter u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .in_ovr(in_ovr), .cfg_test_mode(cfg_test_mode), .cfg_coding(cfg_coding),
        .cfg_user1_lo(u1lo), .cfg_user1_hi(u1hi),
        .cfg_user2_lo(u2lo), .cfg_user2_hi(u2hi),
        .out_valid(out_valid), .out_data(out_data), .out_ovr(out_ovr)
    );

    task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] pick(input logic [3:0] m, input logic [11:0] s, input bit ph);
        int v;
        case (m)
            4'd1: return 12'd2048;
            4'd2: return 12'd4095;
            4'd3: return 12'd0;
            4'd4: return ph ? 12'd1365 : 12'd2730;
            4'd7: return ph ? 12'((u2hi % 16) * 256 + u2lo) : 12'((u1hi % 16) * 256 + u1lo);
            default: return s;
        endcase
    endfunction

    function automatic logic [11:0] code(input logic [1:0] c, input logic [11:0] w);
        case (c)
            2'd1: return 12'((int'(w) + 2048) % 4096);
            2'd2: return w ^ (w / 2);
            default: return w;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] m, input logic [1:0] c);
        if (c == 2'd1) return "R9";
        if (c == 2'd2) return "R10";
        if (c == 2'd3) return "R11";
        case (m)
            4'd0: return "R4";
            4'd1, 4'd2, 4'd3: return "R5";
            4'd4: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    // drive at negedge, check after the capturing edge
    task automatic send(input logic [3:0] m, input logic [1:0] c,
                        input logic [11:0] s, input bit ovr);
        logic [11:0] exp;
        exp = code(c, pick(m, s, phase));
        cfg_test_mode = m; cfg_coding = c; in_sample = s; in_ovr = ovr; in_valid = 1'b1;
        @(posedge clk); #2;
        check(req_of(m, c), out_data, exp);
        check("R3", {11'd0, out_ovr}, {11'd0, ovr});
        check("R2", {11'd0, out_valid}, 12'd1);
        phase = ~phase;
        @(negedge clk);
    endtask

    task automatic idle(input logic [11:0] garbage);
        logic [11:0] held; logic ho;
        held = out_data; ho = out_ovr;
        in_valid = 1'b0; in_sample = garbage; in_ovr = ~in_ovr;
        @(posedge clk); #2;
        check("R2", out_data, held);
        check("R2", {11'd0, out_ovr}, {11'd0, ho});
        check("R2", {11'd0, out_valid}, 12'd0);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1; n_bad++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        check("R1", out_data, 12'd0);
        check("R1", {10'd0, out_valid, out_ovr}, 12'd0);
        rst = 1'b0;
        @(posedge clk); #2;
        check("R1", {out_data[10:0], out_valid}, 12'd0);
        @(negedge clk);
        // R4/R9/R10/R11: every sample value, coding rotating
        for (int i = 0; i < 4096; i++) send(4'd0, 2'(i % 4), 12'(i), (i % 3) == 0);
        // R12: phase must hold across idle cycles; modes x codings sweep
        for (int m = 0; m < 16; m++)
            for (int c = 0; c < 4; c++) begin
                send(4'(m), 2'(c), 12'((m * 293 + c * 71) % 4096), c[0]);
                idle(12'hBAD);
                send(4'(m), 2'(c), 12'((m * 517 + 1000) % 4096), ~c[0]);
                send(4'(m), 2'(c), 12'(m * 9), 1'b1);
            end
        // R7: upper nibble of high bytes ignored
        u1hi = 8'h05; u2hi = 8'hE5;
        for (int k = 0; k < 4; k++) send(4'd7, 2'd0, 12'h123, 1'b0);
        // R12: checker phase across several gaps
        for (int k = 0; k < 6; k++) begin
            send(4'd4, 2'd0, 12'h0, 1'b0);
            if (k % 2 == 0) idle(12'h777);
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule